// File: doc/BRIEF.md
# Pattern-Textured Pixel Combine Unit

The unit merges one 4-bit source pixel with one 4-bit destination pixel and returns the new destination pixel. The merge goes through a programmable lookup table of 256 words, each 16 bits wide. Each word holds four candidate result pixels. The destination pixel's position inside a 2x2 screen tile picks one of the four. A table can therefore lay an ordered dither or texture over the result. This gives more apparent colours than sixteen, even though every stored pixel is still four bits.

Software or a loader fills the table through a simple write port. Pixel traffic then flows as a stream of requests. Each request carries the two colours and the parity of the destination X and Y coordinates. The unit accepts one request per cycle and answers two cycles later.

A two-state controller gates acceptance. `ST_HOLD` is entered on reset and keeps `ready` low. The transition HOLD to RUN happens unconditionally on the first clock edge with reset released. `ST_RUN` keeps `ready` high until the next reset.

Top module: `pix_texture_combine`

## Requirements
- R1: The table word used for a request is the one at index {source, destination}, with the source pixel in bits 7:4 and the destination pixel in bits 3:0.
- R2: The chosen slot number is 2*yodd + xodd.
- R3: Slot 0 is bits 15:12 of the word, slot 1 is bits 11:8, slot 2 is bits 7:4 and slot 3 is bits 3:0.
- R4: A request accepted at a clock edge (req_valid and ready both high) produces resp_valid high, with its pixel, exactly two clock edges later. Back-to-back requests produce back-to-back responses.
- R5: A table write at one edge is seen by any request accepted at a later edge.
- R6: A request accepted at the same edge as a table write to its own index returns the word held before that write.
- R7: While rst_n is low, ready and resp_valid are low. After release, ready stays low until the first clock edge and is high afterwards.
- R8: A request presented while ready is low is ignored and produces no response.
- R9: When resp_valid is low, resp_nib reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table write index |
| tbl_data | input | 16 | Table write word |
| req_valid | input | 1 | Request present |
| req_src | input | 4 | Source pixel |
| req_dst | input | 4 | Destination pixel |
| req_xodd | input | 1 | Destination X parity |
| req_yodd | input | 1 | Destination Y parity |
| ready | output | 1 | Unit accepts requests |
| resp_valid | output | 1 | Response present |
| resp_nib | output | 4 | New destination pixel |

## Verification
The assertions take for granted that the request inputs are meaningful only when req_valid is high. They also assume reset is held for at least one clock edge before traffic starts. The stimulus fills every table word before it issues random lookups, so every expected pixel comes from a known word. Directed sequences then cover the following cases:
- a write followed at once by a read of the same index;
- a write and a read of the same index in the same cycle;
- a request offered while ready is still low.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    parameter int PTC_PIX_W = 4;
    parameter int PTC_SLOTS = 4;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } ptc_state_e;
endpackage

// File: rtl/ptc_lut_ram.sv
module ptc_lut_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // read-before-write: a same-edge write is not visible here
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/ptc_phase_select.sv
module ptc_phase_select #(
    parameter int PIX_W = 4,
    parameter int SLOTS = 4
) (
    input  logic [PIX_W*SLOTS-1:0]   word,
    input  logic [$clog2(SLOTS)-1:0] slot,
    output logic [PIX_W-1:0]         pix
);
    localparam int WORD_W = PIX_W * SLOTS;

    logic [PIX_W-1:0] lanes [SLOTS];

    // slot 0 lives in the top bits, the last slot in the bottom bits
    for (genvar k = 0; k < SLOTS; k++) begin : g_lane
        assign lanes[k] = word[WORD_W-1-k*PIX_W -: PIX_W];
    end

    assign pix = lanes[slot];
endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
    import ptc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    ptc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                ready = 1'b1;
            end
            default: begin
                state_d = ST_HOLD;
            end
        endcase
    end
endmodule

// File: rtl/pix_texture_combine.sv
module pix_texture_combine
    import ptc_pkg::*;
#(
    parameter int PIX_W  = PTC_PIX_W,
    parameter int SLOTS  = PTC_SLOTS,
    parameter int IDX_W  = 2 * PIX_W,
    parameter int WORD_W = PIX_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [WORD_W-1:0] tbl_data,
    input  logic              req_valid,
    input  logic [PIX_W-1:0]  req_src,
    input  logic [PIX_W-1:0]  req_dst,
    input  logic              req_xodd,
    input  logic              req_yodd,
    output logic              ready,
    output logic              resp_valid,
    output logic [PIX_W-1:0]  resp_nib
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic              accept;
    logic [IDX_W-1:0]  lookup_idx;
    logic [WORD_W-1:0] s1_word;
    logic              s1_valid;
    logic [SLOT_W-1:0] s1_slot;
    logic [PIX_W-1:0]  s1_pix;

    ptc_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    assign accept     = req_valid && ready;
    assign lookup_idx = {req_src, req_dst};

    ptc_lut_ram #(.ADDR_W(IDX_W), .DATA_W(WORD_W)) u_lut (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .re    (accept),
        .raddr (lookup_idx),
        .rdata (s1_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_slot  <= '0;
        end else begin
            s1_valid <= accept;
            s1_slot  <= SLOT_W'({req_yodd, req_xodd});
        end
    end

    ptc_phase_select #(.PIX_W(PIX_W), .SLOTS(SLOTS)) u_sel (
        .word (s1_word),
        .slot (s1_slot),
        .pix  (s1_pix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_nib   <= '0;
        end else begin
            resp_valid <= s1_valid;
            resp_nib   <= s1_valid ? s1_pix : '0;
        end
    end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int PIX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ready,
    input logic             resp_valid,
    input logic [PIX_W-1:0] resp_nib
);
    logic acc_d1, acc_d2, seen_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_d1    <= 1'b0;
            acc_d2    <= 1'b0;
            seen_edge <= 1'b0;
        end else begin
            acc_d1    <= req_valid && ready;
            acc_d2    <= acc_d1;
            seen_edge <= 1'b1;
        end
    end

    // R4
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid == acc_d2);

    // R7
    ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready == seen_edge);

    // R8
    no_resp_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ready) |=> ##1 !resp_valid || acc_d2);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> resp_nib == '0);
endmodule

bind pix_texture_combine ptc_checker #(.PIX_W(PIX_W)) u_ptc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ready      (ready),
    .resp_valid (resp_valid),
    .resp_nib   (resp_nib)
);

// File: tb/tb_pix_texture_combine.sv
`timescale 1ns/1ps
module tb_pix_texture_combine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_src = '0, req_dst = '0;
    logic        req_xodd = 1'b0, req_yodd = 1'b0;
    logic        ready, resp_valid;
    logic [3:0]  resp_nib;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [15:0] shadow [256];
    bit          e1v = 0, e2v = 0;
    logic [3:0]  e1d = '0, e2d = '0;
    string       e1t = "", e2t = "";

    always #2.5 clk = ~clk;

    pix_texture_combine dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .req_valid(req_valid), .req_src(req_src),
        .req_dst(req_dst), .req_xodd(req_xodd), .req_yodd(req_yodd),
        .ready(ready), .resp_valid(resp_valid), .resp_nib(resp_nib)
    );

    // R2 and R3: slot 2*y+x, slot 0 in the top bits
    function automatic logic [3:0] pick(logic [15:0] w, bit x, bit y);
        int n = 2 * int'(y) + int'(x);
        return w[15 - 4*n -: 4];
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit we, logic [7:0] wa, logic [15:0] wd,
                       bit rv, logic [3:0] s, logic [3:0] d, bit x, bit y, string tag);
        bit acc;
        @(negedge clk);
        // R4 timing, R9 idle value
        chk(resp_valid == e2v, {e2t, " R4 valid"}, resp_valid, e2v);
        if (e2v) chk(resp_nib == e2d, {e2t, " data"}, resp_nib, e2d);
        else     chk(resp_nib == 4'h0, "R9 idle nibble", resp_nib, 0);
        e2v = e1v; e2d = e1d; e2t = e1t;
        acc = rv && ready;
        tbl_we = we; tbl_addr = wa; tbl_data = wd;
        req_valid = rv; req_src = s; req_dst = d; req_xodd = x; req_yodd = y;
        e1v = acc;
        // R1 index {src,dst}; R6 same-edge read returns old word
        e1d = acc ? pick(shadow[{s, d}], x, y) : 4'h0;
        e1t = tag;
        if (we) shadow[wa] = wd;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        // R7: outputs low during reset
        repeat (3) begin
            @(negedge clk);
            chk(ready == 1'b0, "R7 ready in reset", ready, 0);
            chk(resp_valid == 1'b0, "R7 valid in reset", resp_valid, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R8: request offered while ready is still low
        req_valid = 1'b1; req_src = 4'h1; req_dst = 4'h2;
        chk(ready == 1'b0, "R7 ready before first edge", ready, 0);
        e1v = 0; e2v = 0; e1t = "R8 blocked"; e2t = "R8 blocked";
        @(posedge clk);
        #1;
        chk(ready == 1'b1, "R7 ready after first edge", ready, 1);

        // fill the table
        for (int i = 0; i < 256; i++) begin
            cyc(1, 8'(i), 16'($urandom), 0, 0, 0, 0, 0, "fill");
        end

        // R3: known word, all four phases back to back
        cyc(1, 8'h35, 16'hABCD, 0, 0, 0, 0, 0, "R3 setup");
        cyc(0, 0, 0, 1, 4'h3, 4'h5, 0, 0, "R3 slot0");
        cyc(0, 0, 0, 1, 4'h3, 4'h5, 1, 0, "R3 slot1");
        cyc(0, 0, 0, 1, 4'h3, 4'h5, 0, 1, "R3 slot2");
        cyc(0, 0, 0, 1, 4'h3, 4'h5, 1, 1, "R3 slot3");
        // R1: swapped source/destination hits another word
        cyc(1, 8'h53, 16'h1234, 0, 0, 0, 0, 0, "R1 setup");
        cyc(0, 0, 0, 1, 4'h5, 4'h3, 0, 0, "R1 swapped index");
        // R5: write then lookup on the next cycle
        cyc(1, 8'hC7, 16'h9876, 0, 0, 0, 0, 0, "R5 write");
        cyc(0, 0, 0, 1, 4'hC, 4'h7, 1, 0, "R5 next cycle read");
        // R6: write and lookup on the same cycle
        cyc(1, 8'hC7, 16'h0F0F, 1, 4'hC, 4'h7, 0, 0, "R6 same cycle read");
        cyc(0, 0, 0, 1, 4'hC, 4'h7, 0, 0, "R5 after overwrite");

        // random mix: R1 R2 R4 R5 R6
        for (int i = 0; i < 2000; i++) begin
            cyc(($urandom % 4) == 0, 8'($urandom), 16'($urandom),
                ($urandom % 4) != 0, 4'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom), "R2 random");
        end
        // drain
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "drain");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "drain");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "drain");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule